// File: doc/BRIEF.md
# Strided Vector Address Generator over Interleaved Memory Banks

This block turns a vector memory operation into a stream of word addresses and runs them against a word-interleaved memory of single-ported banks. Software-visible state is a start base, a stride and an element count. These values are latched when an operation is accepted. Element `i` then targets word `base + i*stride`, and the low address bits select the bank. Each access holds its bank for a fixed number of cycles. The issue stage starts at most one access per cycle and waits in place whenever the bank of the next element is still occupied.

For a load, each element comes back a fixed number of cycles after it was issued. It carries its element index and a valid strobe, so results arrive in element order. A store takes its write data in the same cycle the element is issued. A one-cycle completion pulse closes every operation. Bank occupancy carries across operations, so a new vector can be held back by accesses left from the previous one. Throughput therefore follows from the stride. A stride with no common factor with the bank count streams one element per cycle. Strides that share a factor fold onto fewer banks and stall.

Top module: `stride_bank_agu`

## Requirements
- R1: Element i of an operation is issued on `issue_addr_o` as (base + i*stride) modulo 2^ADDR_W, elements go out in index order 0..vlen-1, each exactly once, and nothing is issued while `busy_o` is low.
- R2: `issue_bank_o` equals the issued word address modulo NUM_BANKS (its low BANK_W bits).
- R3: A bank that started an access in cycle c accepts its next access no earlier than cycle c+BANK_LAT (11), including across back-to-back operations.
- R4: With a stride that is odd (relatively prime to 16) and banks free at start, elements issue in consecutive cycles, so the last element issues vlen-1 cycles after the first.
- R5: With a stride that shares a factor with 16, issue stalls until the target bank is free; stride 0 issues one element every 11 cycles.
- R6: For a load, element i appears on `ld_valid_o`/`ld_idx_o` exactly BANK_LAT-1 (10) cycles after its issue cycle, in index order, with `ld_data_o` equal to the word last stored at its address; a unit-stride load of n elements thus spans 11+n-1 cycles.
- R7: For a store, `issue_idx_o` shows the element index in its issue cycle and `st_data_i` sampled in that cycle is written to the issued address.
- R8: `done_o` is a one-cycle pulse with `busy_o` low in that cycle: for a store in the cycle after the last issue, for a load in the cycle after the last return, and for vlen 0 in the cycle after `start_i` is accepted with no issue.
- R9: `start_i` has no effect while `busy_o` is high.
- R10: After reset `busy_o`, `done_o`, `issue_o` and `ld_valid_o` are low and all banks are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation (accepted when idle) |
| store_i | input | 1 | 1 = store operation, 0 = load |
| base_i | input | ADDR_W | Word address of element 0 |
| stride_i | input | ADDR_W | Word distance between elements (modulo 2^ADDR_W) |
| vlen_i | input | VLEN_W | Number of elements, 0..MAX_VL |
| st_data_i | input | DATA_W | Store data for the element shown on `issue_idx_o` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| issue_o | output | 1 | A bank access starts this cycle |
| issue_addr_o | output | ADDR_W | Word address of the access starting |
| issue_bank_o | output | BANK_W | Bank of the access starting |
| issue_idx_o | output | IDX_W | Element index of the access starting |
| ld_valid_o | output | 1 | Load element returned this cycle |
| ld_idx_o | output | IDX_W | Element index of the returned load |
| ld_data_o | output | DATA_W | Returned load data |

## Verification
A bank counter that is wrong shows up at once in the issue timing: an access to a busy bank gives an issue gap below 11 cycles, and a counter that never clears freezes issue. The bench catches both through the issue cycle of every element and through the span of each stride pattern. A wrong address or stride latch is visible on the first or second issue after start. A damaged return delay line shows up on the first returned element, as a wrong index, a wrong data word or a shift away from 10 cycles. Errors in the state machine show up as a misplaced `done_o` pulse or as a start that is taken while busy.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_IDLE  = 2'd0,
    AGU_ISSUE = 2'd1,
    AGU_DRAIN = 2'd2
  } agu_state_e;
endpackage

// File: rtl/agu_addr_gen.sv
module agu_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] stride_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      stride_q <= '0;
      idx_o    <= '0;
    end else if (load_i) begin
      addr_o   <= base_i;
      stride_q <= stride_i;
      idx_o    <= '0;
    end else if (step_i) begin
      addr_o <= addr_o + stride_q;
      idx_o  <= idx_o + IDX_W'(1);
    end
  end
endmodule

// File: rtl/bank_busy_track.sv
module bank_busy_track #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_LAT  = 11,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(BANK_LAT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] busy_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    // issue cycle counts as the first of BANK_LAT occupied cycles
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cnt_q <= '0;
      else if (issue_i && bank_i == BANK_W'(b)) cnt_q <= CNT_W'(BANK_LAT - 1);
      else if (cnt_q != '0)                     cnt_q <= cnt_q - CNT_W'(1);
    end
    assign busy_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/ret_pipe.sv
module ret_pipe #(
  parameter int DEPTH  = 10,
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pend_o
);
  logic [DEPTH-1:0] v_q;
  logic [IDX_W-1:0] idx_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= {v_q[DEPTH-2:0], push_i};
  end

  always_ff @(posedge clk_i) begin
    idx_q[0]  <= idx_i;
    addr_q[0] <= addr_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i) begin
      idx_q[k]  <= idx_q[k-1];
      addr_q[k] <= addr_q[k-1];
    end
  end

  assign valid_o = v_q[DEPTH-1];
  assign idx_o   = idx_q[DEPTH-1];
  assign addr_o  = addr_q[DEPTH-1];
  // loads still in flight behind the output stage
  assign pend_o  = |v_q[DEPTH-2:0];
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 6,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROWS     = 1 << ROW_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wbank_i,
  input  logic [ROW_W-1:0]  wrow_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] rbank_i,
  input  logic [ROW_W-1:0]  rrow_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_all [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    always_ff @(posedge clk_i) begin
      if (we_i && wbank_i == BANK_W'(b)) mem[wrow_i] <= wdata_i;
    end
    assign rd_all[b] = mem[rrow_i];
  end

  assign rdata_o = rd_all[rbank_i];
endmodule

// File: rtl/stride_bank_agu.sv
module stride_bank_agu
  import agu_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int BANK_LAT  = 11,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int MAX_VL    = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - BANK_W,
  localparam int IDX_W    = $clog2(MAX_VL),
  localparam int VLEN_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VLEN_W-1:0] vlen_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              issue_o,
  output logic [ADDR_W-1:0] issue_addr_o,
  output logic [BANK_W-1:0] issue_bank_o,
  output logic [IDX_W-1:0]  issue_idx_o,
  output logic              ld_valid_o,
  output logic [IDX_W-1:0]  ld_idx_o,
  output logic [DATA_W-1:0] ld_data_o
);
  agu_state_e        state_q;
  logic              store_q;
  logic [VLEN_W-1:0] vlen_q;
  logic              done_q;
  logic              accept;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [BANK_W-1:0] cur_bank;
  logic [NUM_BANKS-1:0] bank_busy;
  logic              can_issue;
  logic              last_elem;
  logic              ret_pend;
  logic [ADDR_W-1:0] ret_addr;

  assign accept    = start_i && (state_q == AGU_IDLE);
  assign cur_bank  = cur_addr[BANK_W-1:0];
  assign can_issue = (state_q == AGU_ISSUE) && !bank_busy[cur_bank];
  assign last_elem = (VLEN_W'(cur_idx) == vlen_q - VLEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= AGU_IDLE;
      store_q <= 1'b0;
      vlen_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        AGU_IDLE: if (accept) begin
          store_q <= store_i;
          vlen_q  <= vlen_i;
          if (vlen_i == '0) done_q  <= 1'b1;
          else              state_q <= AGU_ISSUE;
        end
        AGU_ISSUE: if (can_issue && last_elem) begin
          if (store_q) begin
            state_q <= AGU_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= AGU_DRAIN;
          end
        end
        AGU_DRAIN: if (!ret_pend) begin
          state_q <= AGU_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= AGU_IDLE;
      endcase
    end
  end

  agu_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .base_i   (base_i),
    .stride_i (stride_i),
    .step_i   (can_issue),
    .addr_o   (cur_addr),
    .idx_o    (cur_idx)
  );

  bank_busy_track #(.NUM_BANKS(NUM_BANKS), .BANK_LAT(BANK_LAT)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (can_issue),
    .bank_i  (cur_bank),
    .busy_o  (bank_busy)
  );

  ret_pipe #(.DEPTH(BANK_LAT - 1), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (can_issue && !store_q),
    .idx_i   (cur_idx),
    .addr_i  (cur_addr),
    .valid_o (ld_valid_o),
    .idx_o   (ld_idx_o),
    .addr_o  (ret_addr),
    .pend_o  (ret_pend)
  );

  bank_store #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (can_issue && store_q),
    .wbank_i (cur_bank),
    .wrow_i  (cur_addr[ADDR_W-1:BANK_W]),
    .wdata_i (st_data_i),
    .rbank_i (ret_addr[BANK_W-1:0]),
    .rrow_i  (ret_addr[ADDR_W-1:BANK_W]),
    .rdata_o (ld_data_o)
  );

  assign busy_o       = (state_q != AGU_IDLE);
  assign done_o       = done_q;
  assign issue_o      = can_issue;
  assign issue_addr_o = cur_addr;
  assign issue_bank_o = cur_bank;
  assign issue_idx_o  = cur_idx;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_LAT  = 11,
  parameter int ADDR_W    = 10,
  parameter int IDX_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int GAP_W    = $clog2(BANK_LAT + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] stride_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              issue_o,
  input logic [ADDR_W-1:0] issue_addr_o,
  input logic [BANK_W-1:0] issue_bank_o,
  input logic              ld_valid_o,
  input logic [IDX_W-1:0]  ld_idx_o
);
  logic              taken;
  logic [ADDR_W-1:0] base_q, stride_q, prev_addr;
  logic              have_prev, ret_seen;
  logic [IDX_W-1:0]  prev_ret;

  assign taken = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0; stride_q <= '0; prev_addr <= '0;
      have_prev <= 1'b0; ret_seen <= 1'b0; prev_ret <= '0;
    end else begin
      if (taken) begin
        base_q <= base_i; stride_q <= stride_i;
        have_prev <= 1'b0; ret_seen <= 1'b0;
      end else begin
        if (issue_o)    begin have_prev <= 1'b1; prev_addr <= issue_addr_o; end
        if (ld_valid_o) begin ret_seen  <= 1'b1; prev_ret  <= ld_idx_o;     end
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    gap_q <= GAP_W'(BANK_LAT);
      else if (issue_o && issue_bank_o == BANK_W'(b)) gap_q <= GAP_W'(1);
      else if (gap_q < GAP_W'(BANK_LAT))              gap_q <= gap_q + GAP_W'(1);
    end
    AST_BANK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_o && issue_bank_o == BANK_W'(b)) |-> gap_q >= GAP_W'(BANK_LAT)); // R3
  end

  AST_FIRST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && !have_prev) |-> issue_addr_o == base_q); // R1
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && have_prev) |-> issue_addr_o == ADDR_W'(prev_addr + stride_q)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !issue_o); // R1
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !issue_o && !ld_valid_o)); // R8
  AST_RET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && !ret_seen) |-> ld_idx_o == '0); // R6
  AST_RET_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && ret_seen) |-> ld_idx_o == IDX_W'(prev_ret + IDX_W'(1))); // R6
endmodule

bind stride_bank_agu agu_checker #(
  .NUM_BANKS(NUM_BANKS), .BANK_LAT(BANK_LAT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_agu_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .base_i       (base_i),
  .stride_i     (stride_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .issue_o      (issue_o),
  .issue_addr_o (issue_addr_o),
  .issue_bank_o (issue_bank_o),
  .ld_valid_o   (ld_valid_o),
  .ld_idx_o     (ld_idx_o)
);

// File: tb/tb_stride_bank_agu.sv
`timescale 1ns/1ps
module tb_stride_bank_agu;
  localparam int AW = 10, DW = 16, VW = 7, IW = 6, BW = 4;
  localparam int NT = 9;
  localparam int T_BASE   [NT] = '{5, 100, 7, 0, 300, 40, 200, 1000, 512};
  localparam int T_STRIDE [NT] = '{1,   3, 0, 2,   4,  8,  16,    5, 1023};
  localparam int T_N      [NT] = '{20, 20, 4, 10,  6,  3,   3,   16,  64};
  localparam int T_SPAN   [NT] = '{19, 19, 33, 12, 12, 11, 22,   15,  63};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, store = 1'b0;
  logic [AW-1:0] base_v = '0, stride_v = '0;
  logic [VW-1:0] vlen = '0;
  logic [DW-1:0] st_data;
  logic busy, done, issue, ld_valid;
  logic [AW-1:0] iaddr;
  logic [BW-1:0] ibank;
  logic [IW-1:0] iidx, lidx;
  logic [DW-1:0] ldata;

  int cyc = 0, n_chk = 0, n_fail = 0, cur_tag = 0;
  int iss_cyc [64];
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign st_data = DW'((cur_tag << 6) | int'(iidx));

  stride_bank_agu dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .store_i(store),
    .base_i(base_v), .stride_i(stride_v), .vlen_i(vlen), .st_data_i(st_data),
    .busy_o(busy), .done_o(done), .issue_o(issue), .issue_addr_o(iaddr),
    .issue_bank_o(ibank), .issue_idx_o(iidx), .ld_valid_o(ld_valid),
    .ld_idx_o(lidx), .ld_data_o(ldata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic run_op(input bit st, input int base, input int stride, input int n,
                        input int tag, output int span);
    int k = 0, r = 0, first = -1, last = -1, last_ret = -1, t0, ea, ed;
    bit fin = 0;
    cur_tag = tag;
    @(negedge clk);
    start = 1'b1; store = st; base_v = AW'(base); stride_v = AW'(stride); vlen = VW'(n);
    t0 = cyc;
    while (!fin) begin
      @(negedge clk);
      start = 1'b0;
      if (issue) begin
        ea = (base + k * stride) % 1024;
        chk(int'(iaddr) == ea, "R1", iaddr, ea);
        chk(int'(ibank) == ea % 16, "R2", ibank, ea % 16);
        chk(int'(iidx) == k, "R7", iidx, k);
        if (k < 64) iss_cyc[k] = cyc;
        if (first < 0) first = cyc;
        last = cyc;
        k++;
      end
      if (ld_valid) begin
        chk(!st, "R6", 1, 0);
        chk(int'(lidx) == r, "R6", lidx, r);
        if (r < 64 && r < k) chk(cyc - iss_cyc[r] == 10, "R6", cyc - iss_cyc[r], 10);
        ed = (stride == 0) ? ((tag << 6) | (n - 1)) : ((tag << 6) | r);
        chk(int'(ldata) == ed, "R6", ldata, ed);
        last_ret = cyc;
        r++;
      end
      if (done) fin = 1;
      if (cyc - t0 > 3000) begin chk(0, "WDOG", cyc - t0, 3000); fin = 1; end
    end
    chk(k == n, "R1", k, n);
    if (!st) chk(r == n, "R6", r, n);
    chk(busy == 1'b0, "R8", busy, 0);
    if (n == 0)  chk(cyc == t0 + 1, "R8", cyc - t0, 1);
    else if (st) chk(cyc == last + 1, "R8", cyc - last, 1);
    else         chk(cyc == last_ret + 1, "R8", cyc - last_ret, 1);
    span = last - first;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      chk(0, "WDOG", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int sp;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10", busy, 0);
    chk(done == 1'b0, "R10", done, 0);
    chk(issue == 1'b0, "R10", issue, 0);
    chk(ld_valid == 1'b0, "R10", ld_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // stride table: store pass then load-back pass
    for (int e = 0; e < NT; e++) begin
      run_op(1'b1, T_BASE[e], T_STRIDE[e], T_N[e], e + 1, sp);
      chk(sp == T_SPAN[e], (T_STRIDE[e] % 2 == 1) ? "R4" : "R5", sp, T_SPAN[e]);
      run_op(1'b0, T_BASE[e], T_STRIDE[e], T_N[e], e + 1, sp);
      chk(sp == T_SPAN[e], (T_STRIDE[e] % 2 == 1) ? "R4" : "R5", sp, T_SPAN[e]);
    end

    // R8: zero-length operation
    run_op(1'b0, 0, 1, 0, 30, sp);

    // R9: start while busy is ignored
    begin
      int n_iss = 0, n_ret = 0;
      @(negedge clk);
      start = 1'b1; store = 1'b0; base_v = 10'd64; stride_v = 10'd1; vlen = 7'd5;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        start = (c == 2);
        store = (c == 2);
        vlen  = (c == 2) ? 7'd2 : 7'd5;
        if (issue) n_iss++;
        if (ld_valid) n_ret++;
      end
      chk(n_iss == 5, "R9", n_iss, 5);
      chk(n_ret == 5, "R9", n_ret, 5);
      chk(busy == 1'b0, "R9", busy, 0);
    end

    // R3: bank occupancy carries into the next operation
    begin
      int c1 = -1, c2 = -1;
      repeat (12) @(negedge clk);
      start = 1'b1; store = 1'b1; base_v = 10'd0; stride_v = 10'd1; vlen = 7'd1;
      for (int c = 0; c < 10 && !done; c++) begin
        @(negedge clk);
        start = 1'b0;
        if (issue) c1 = cyc;
      end
      start = 1'b1; store = 1'b0; base_v = 10'd16; vlen = 7'd1;
      for (int c = 0; c < 30 && c2 < 0; c++) begin
        @(negedge clk);
        start = 1'b0;
        if (issue) begin
          c2 = cyc;
          chk(ibank == 4'd0, "R2", ibank, 0);
        end
      end
      chk(c2 - c1 == 11, "R3", c2 - c1, 11);
      repeat (20) @(negedge clk);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule